// File: doc/BRIEF.md
# Hierarchical Global Miss Detector

This block sits beside a tree of small cache tiles that a request searches one latency level per cycle. Every tile that takes part in a lookup reports a valid and a hit bit, and each level reports a strobe with the 4-bit miss-status tag of the request being searched there. For every tile, the block produces a forward signal that lets the search continue into that tile's children only on a miss. A tile that hits therefore cuts its own subtree off.

For each request, the block records whether any tile on the way down has hit. When the request reaches the deepest level, the block resolves it. A global miss is reported only when every deepest-level tile looked up and missed and no hit was recorded for that tag. If any hit was seen, a global hit is reported instead. The miss condition comes from a segmented OR reduction: tiles are grouped into short segments, the segments are ORed, and the segment outputs are ORed again, so the logic depth grows slowly with the tile count. Several requests with different tags may be in flight at different levels at the same time.

Top module: `global_miss_detector`

## Requirements
- R1: `fwd_o[l*N_TILE+t]` equals tile valid AND NOT tile hit for that tile, combinationally, regardless of level strobes.
- R2: One cycle after a deepest-level strobe, `gmiss_o` pulses for exactly one cycle when all of the following hold: every deepest-level tile was valid, none hit, and no hit was recorded for that tag. `res_tag_o` then carries the tag from the deepest-level strobe.
- R3: A hit in a valid tile at a non-deepest level, under its level strobe, is recorded for that tag. At the later deepest-level resolution it suppresses `gmiss_o` and raises `ghit_o` for one cycle instead.
- R4: A valid hit at the deepest level raises `ghit_o`, and not `gmiss_o`, one cycle later.
- R5: If a deepest-level strobe has some tile not valid and no hit from any source, neither pulse is raised.
- R6: Each of the 16 tags is tracked independently. Overlapping requests at different levels do not affect each other's results.
- R7: A deepest-level resolution clears that tag's recorded hit, so a reused tag starts clean. A new hit for the same tag recorded in the same cycle is kept.
- R8: Active-low reset clears all recorded hits and both result pulses.
- R9: Tile hits at a level whose strobe is low are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tile_vld_i | input | N_LVL*N_TILE | Tile lookup valid, index level*N_TILE+tile |
| tile_hit_i | input | N_LVL*N_TILE | Tile lookup hit, same indexing |
| lvl_vld_i | input | N_LVL | Level carries a request this cycle |
| lvl_tag_i | input | N_LVL*TAG_W | Tag per level, bits [l*TAG_W +: TAG_W] |
| fwd_o | output | N_LVL*N_TILE | Miss forwarded to the tile's children |
| gmiss_o | output | 1 | Global miss pulse |
| ghit_o | output | 1 | Global hit pulse |
| res_tag_o | output | TAG_W | Tag of the resolved request |

## Verification
The forward mask is combinational, so the bench checks it one time step after the inputs are driven, within the same cycle. Both result pulses and their tag are registered once, so they are due on the clock edge that follows the deepest-level strobe. The behavioural model predicts them from the inputs it applied before that edge and compares them at the next falling edge. Recorded hits only show up at a later resolution, so the hit-pruning, reuse, ignored-strobe and reset cases each end with a deepest-level strobe for the affected tag.

// File: rtl/gmd_pkg.sv
package gmd_pkg;
  parameter int unsigned GMD_TAG_W = 4;
endpackage

// File: rtl/gmd_seg_or.sv
module gmd_seg_or #(
  parameter int unsigned N   = 8,
  parameter int unsigned SEG = 2
) (
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  localparam int unsigned NSEG = (N + SEG - 1) / SEG;
  logic [NSEG-1:0] seg_or;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG-1:0] part;
    for (genvar k = 0; k < SEG; k++) begin : g_bit
      if (s * SEG + k < N) begin : g_on
        assign part[k] = in_i[s*SEG+k];
      end else begin : g_off
        assign part[k] = 1'b0;
      end
    end
    assign seg_or[s] = |part;
  end

  assign out_o = |seg_or;
endmodule

// File: rtl/gmd_level.sv
module gmd_level #(
  parameter int unsigned N_TILE = 4,
  parameter int unsigned SEG    = 2
) (
  input  logic [N_TILE-1:0] vld_i,
  input  logic [N_TILE-1:0] hit_i,
  output logic [N_TILE-1:0] fwd_o,
  output logic              any_hit_o,
  output logic              all_miss_o
);
  logic [N_TILE-1:0] vhit, not_missed;
  logic              any_not_missed;

  assign fwd_o      = vld_i & ~hit_i;
  assign vhit       = vld_i & hit_i;
  assign not_missed = ~fwd_o;

  gmd_seg_or #(.N(N_TILE), .SEG(SEG)) u_hit_or (.in_i(vhit), .out_o(any_hit_o));
  gmd_seg_or #(.N(N_TILE), .SEG(SEG)) u_nm_or  (.in_i(not_missed), .out_o(any_not_missed));

  assign all_miss_o = ~any_not_missed;
endmodule

// File: rtl/gmd_hit_tbl.sv
module gmd_hit_tbl #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned N_SET = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SET-1:0]       set_i,
  input  logic [N_SET*TAG_W-1:0] set_tag_i,
  input  logic                   clr_i,
  input  logic [TAG_W-1:0]       clr_tag_i,
  output logic                   seen_o
);
  localparam int unsigned N_TAG = 1 << TAG_W;
  logic [N_TAG-1:0] seen_q, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    for (int l = 0; l < N_SET; l++)
      if (set_i[l]) set_vec[set_tag_i[l*TAG_W+:TAG_W]] = 1'b1;
    clr_vec = '0;
    if (clr_i) clr_vec[clr_tag_i] = 1'b1;
  end

  // a fresh set beats the resolution clear of the same tag
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= (seen_q & ~clr_vec) | set_vec;

  assign seen_o = seen_q[clr_tag_i];
endmodule

// File: rtl/global_miss_detector.sv
module global_miss_detector
  import gmd_pkg::*;
#(
  parameter int unsigned N_LVL  = 3,
  parameter int unsigned N_TILE = 4,
  parameter int unsigned SEG    = 2,
  parameter int unsigned TAG_W  = GMD_TAG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LVL*N_TILE-1:0]   tile_vld_i,
  input  logic [N_LVL*N_TILE-1:0]   tile_hit_i,
  input  logic [N_LVL-1:0]          lvl_vld_i,
  input  logic [N_LVL*TAG_W-1:0]    lvl_tag_i,
  output logic [N_LVL*N_TILE-1:0]   fwd_o,
  output logic                      gmiss_o,
  output logic                      ghit_o,
  output logic [TAG_W-1:0]          res_tag_o
);
  localparam int unsigned LAST  = N_LVL - 1;
  localparam int unsigned N_SET = (N_LVL > 1) ? N_LVL - 1 : 1;

  logic [N_LVL-1:0] any_hit, all_miss;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    gmd_level #(.N_TILE(N_TILE), .SEG(SEG)) u_lvl (
      .vld_i     (tile_vld_i[l*N_TILE+:N_TILE]),
      .hit_i     (tile_hit_i[l*N_TILE+:N_TILE]),
      .fwd_o     (fwd_o[l*N_TILE+:N_TILE]),
      .any_hit_o (any_hit[l]),
      .all_miss_o(all_miss[l])
    );
  end

  logic [N_SET-1:0]       set;
  logic [N_SET*TAG_W-1:0] set_tag;

  if (N_LVL > 1) begin : g_set
    assign set     = lvl_vld_i[N_SET-1:0] & any_hit[N_SET-1:0];
    assign set_tag = lvl_tag_i[N_SET*TAG_W-1:0];
  end else begin : g_noset
    assign set     = '0;
    assign set_tag = '0;
  end

  logic             seen;
  logic             fin;
  logic [TAG_W-1:0] fin_tag;

  assign fin     = lvl_vld_i[LAST];
  assign fin_tag = lvl_tag_i[LAST*TAG_W+:TAG_W];

  gmd_hit_tbl #(.TAG_W(TAG_W), .N_SET(N_SET)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .set_tag_i(set_tag),
    .clr_i    (fin),
    .clr_tag_i(fin_tag),
    .seen_o   (seen)
  );

  logic miss_d, hit_d;
  assign hit_d  = fin & (seen | any_hit[LAST]);
  assign miss_d = fin & all_miss[LAST] & ~seen;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      gmiss_o   <= 1'b0;
      ghit_o    <= 1'b0;
      res_tag_o <= '0;
    end else begin
      gmiss_o <= miss_d;
      ghit_o  <= hit_d;
      if (fin) res_tag_o <= fin_tag;
    end
endmodule

// File: rtl/global_miss_detector_chk.sv
module global_miss_detector_chk #(
  parameter int unsigned N_LVL  = 3,
  parameter int unsigned N_TILE = 4,
  parameter int unsigned TAG_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_LVL*N_TILE-1:0] tile_vld_i,
  input logic [N_LVL*N_TILE-1:0] tile_hit_i,
  input logic [N_LVL-1:0]        lvl_vld_i,
  input logic [N_LVL*TAG_W-1:0]  lvl_tag_i,
  input logic [N_LVL*N_TILE-1:0] fwd_o,
  input logic                    gmiss_o,
  input logic                    ghit_o,
  input logic [TAG_W-1:0]        res_tag_o
);
  localparam int unsigned LAST = N_LVL - 1;
  logic              fin;
  logic [TAG_W-1:0]  fin_tag;
  logic [N_TILE-1:0] lv, lh;
  assign fin     = lvl_vld_i[LAST];
  assign fin_tag = lvl_tag_i[LAST*TAG_W+:TAG_W];
  assign lv      = tile_vld_i[LAST*N_TILE+:N_TILE];
  assign lh      = tile_hit_i[LAST*N_TILE+:N_TILE];

  a_r1_no_fwd_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o & tile_hit_i) == '0);
  a_r2_miss_after_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmiss_o |-> $past(fin));
  a_r2_miss_all_looked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmiss_o |-> ($past(lv) == {N_TILE{1'b1}} && $past(lh & lv) == '0));
  a_r2_tag_returned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin ##1 (gmiss_o || ghit_o)) |-> res_tag_o == $past(fin_tag));
  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gmiss_o && ghit_o));
  a_r4_last_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && (lv & lh) != '0) |=> (ghit_o && !gmiss_o));
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> (!gmiss_o && !ghit_o));
endmodule

bind global_miss_detector global_miss_detector_chk #(
  .N_LVL(N_LVL), .N_TILE(N_TILE), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/global_miss_detector_test.sv
`timescale 1ns/1ps
module global_miss_detector_test;
  localparam int L = 3, T = 4, W = 4;

  logic clk = 0, rst_n = 0;
  logic [L*T-1:0] tv = '0, th = '0, fwd;
  logic [L-1:0]   lv = '0;
  logic [L*W-1:0] ltag = '0;
  logic gmiss, ghit;
  logic [W-1:0] rtag;

  global_miss_detector #(.N_LVL(L), .N_TILE(T), .SEG(2), .TAG_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tile_vld_i(tv), .tile_hit_i(th),
    .lvl_vld_i(lv), .lvl_tag_i(ltag), .fwd_o(fwd),
    .gmiss_o(gmiss), .ghit_o(ghit), .res_tag_o(rtag));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string ph = "R8";
  bit [15:0] hs = '0;
  bit e_miss = 0, e_hit = 0;
  bit [W-1:0] e_tag = '0;

  // request pipeline: stage l searches level l
  bit       p_v[L];
  bit [3:0] p_tag[L];
  int       p_hl[L], p_ht[L];

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic compare_out();
    chk(ph, "gmiss", gmiss, e_miss);
    chk(ph, "ghit", ghit, e_hit);
    if (e_miss || e_hit) chk(ph, "res_tag", rtag, e_tag);
  endtask

  // drive at negedge, check comb fwd, update model, run one clock
  task automatic step();
    logic [T-1:0] v, h;
    #1;
    chk("R1", "fwd", fwd, tv & ~th);
    v = tv[(L-1)*T+:T];
    h = th[(L-1)*T+:T];
    e_tag  = ltag[(L-1)*W+:W];
    e_hit  = lv[L-1] && (hs[e_tag] || (v & h) != 0);
    e_miss = lv[L-1] && (v == '1) && ((v & h) == 0) && !hs[e_tag];
    if (lv[L-1]) hs[e_tag] = 0;
    for (int l = 0; l < L-1; l++)
      if (lv[l] && (tv[l*T+:T] & th[l*T+:T]) != 0) hs[ltag[l*W+:W]] = 1;
    @(posedge clk);
    @(negedge clk);
    compare_out();
  endtask

  task automatic raw(logic [L-1:0] a_lv, logic [L*W-1:0] a_tag,
                     logic [L*T-1:0] a_tv, logic [L*T-1:0] a_th);
    lv = a_lv; ltag = a_tag; tv = a_tv; th = a_th;
    step();
  endtask

  task automatic push(bit v, bit [3:0] tag, int hl, int ht);
    for (int l = L-1; l > 0; l--) begin
      p_v[l] = p_v[l-1]; p_tag[l] = p_tag[l-1];
      p_hl[l] = p_hl[l-1]; p_ht[l] = p_ht[l-1];
    end
    p_v[0] = v; p_tag[0] = tag; p_hl[0] = hl; p_ht[0] = ht;
    for (int l = 0; l < L; l++) begin
      lv[l] = p_v[l];
      ltag[l*W+:W] = p_tag[l];
      tv[l*T+:T] = '0; th[l*T+:T] = '0;
      if (p_v[l]) begin
        if (p_hl[l] < l)        tv[l*T+:T] = 4'b1110;     // subtree cut off
        else if (p_hl[l] == l) begin tv[l*T+:T] = '1; th[l*T+:T] = 4'b1 << p_ht[l]; end
        else                    tv[l*T+:T] = '1;
      end
    end
    step();
  endtask

  task automatic drain();
    for (int i = 0; i < L; i++) push(0, 0, 9, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int l = 0; l < L; l++) begin p_v[l] = 0; p_tag[l] = 0; p_hl[l] = 9; p_ht[l] = 0; end
    repeat (2) @(negedge clk);
    chk("R8", "gmiss in reset", gmiss, 0);
    chk("R8", "ghit in reset", ghit, 0);
    rst_n = 1;
    @(negedge clk);

    ph = "R2"; push(1, 4'h3, 9, 0); drain();           // all miss
    ph = "R3"; push(1, 4'h4, 0, 2); drain();           // hit at level 0
    ph = "R3"; push(1, 4'h5, 1, 1); drain();           // hit at level 1
    ph = "R4"; push(1, 4'h6, 2, 3); drain();           // hit at deepest level

    ph = "R5";
    raw(3'b100, {4'h7, 8'h0}, {4'b0111, 8'h0}, '0);
    raw('0, '0, '0, '0);

    ph = "R6";                                         // overlapping requests
    push(1, 4'h1, 0, 0); push(1, 4'h2, 9, 0); push(1, 4'h8, 1, 2);
    push(1, 4'h9, 9, 0); push(1, 4'hA, 2, 0); drain();

    ph = "R7";                                         // reuse tag 4 clean
    push(1, 4'h4, 9, 0); drain();
    // set of tag 0xB at level 0 in the same cycle its old copy resolves
    raw(3'b001, {4'h0, 4'h0, 4'hB}, {8'h0, 4'hF}, {8'h0, 4'h1});
    raw(3'b101, {4'hB, 4'h0, 4'hB}, {4'hF, 4'h0, 4'hF}, {8'h0, 4'h2});
    raw(3'b100, {4'hB, 8'h0}, {4'hF, 8'h0}, '0);
    raw('0, '0, '0, '0);

    ph = "R9";                                         // hit without strobe ignored
    raw(3'b000, {8'h0, 4'hC}, {8'h0, 4'hF}, {8'h0, 4'hF});
    raw(3'b100, {4'hC, 8'h0}, {4'hF, 8'h0}, '0);
    raw('0, '0, '0, '0);

    ph = "R8";                                         // reset drops recorded hit
    raw(3'b001, {8'h0, 4'hD}, {8'h0, 4'hF}, {8'h0, 4'h8});
    rst_n = 0; hs = '0; e_miss = 0; e_hit = 0;
    @(negedge clk); compare_out();
    rst_n = 1;
    raw(3'b100, {4'hD, 8'h0}, {4'hF, 8'h0}, '0);
    raw('0, '0, '0, '0);

    ph = "R6";
    for (int i = 0; i < 400; i++)
      push($urandom_range(0, 3) != 0, 4'($urandom), $urandom_range(0, 4), $urandom_range(0, T-1));
    drain();
    finish_run();
  end
endmodule